// File: doc/BRIEF.md
# Multicast Replicating Switch Element

This block is one c×c switching element of a self-routing multistage network. Each input delivers fixed-size packets whose destination tag has one bit per network output. A set bit marks a wanted destination, so unicast, multicast and broadcast all use the same format. The element cuts the tag into c slices of equal width. Slice j, at bits j*SUB_W upward, belongs to output j. One copy of the packet goes to every output whose slice has at least one set bit, and that copy leaves carrying only its slice as the new tag. Because of this, the tag narrows by a factor of c at each stage.

Each input holds one packet in a slot together with a c-bit mask of copies still owed. Every output runs its own arbiter. When several inputs want the same output, a per-output LFSR picks the starting point of a rotating search, which gives each contender roughly equal odds. The LFSR restarts from a seed parameter at reset, so a run can be reproduced. Copies are delivered independently: a copy that loses arbitration or meets backpressure stays pending while its siblings leave. The slot frees itself only after its last copy has been taken. A packet with an all-zero tag is absorbed on arrival and uses no output.

All ports are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. An input presenting a packet must hold valid, tag and payload steady until ready is seen. An output that raises valid keeps valid, tag and payload stable until its ready is high. Output ready may be held low for any number of cycles to apply backpressure.

Top module: `msw_switch`

## Requirements
- R1: While reset is applied and in the cycle after it, every output valid is low and every input ready is high.
- R2: A copy on output j carries bits [j*SUB_W +: SUB_W] of the packet's tag as its tag and the payload unchanged.
- R3: A packet yields exactly one copy on each output whose slice is nonzero and none elsewhere, so a tag with every slice nonzero reaches all outputs.
- R4: A packet whose tag is all zeros is accepted and produces no output copy, and its input stays ready in the next cycle.
- R5: A copy blocked on one output does not delay its sibling on another output. Both are valid in the cycle after acceptance, and each leaves when its own output is ready.
- R6: Each output carries at most one copy per cycle. When several inputs contend, one is served and the others are served in later cycles, and no copy is lost.
- R7: Once an output raises valid with ready low, valid, tag and payload stay unchanged in the next cycle.
- R8: An input's ready is low from the cycle after it accepts a packet with a nonzero tag until the edge on which its last pending copy is taken.
- R9: Contention is settled by a seeded pseudo-random choice, so over repeated contention for one output each contender wins a substantial share of the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | C | Per input: a packet is offered |
| in_ready | output | C | Per input: the slot can take a packet |
| in_tag | input | C*TAG_W | Destination tags, input i at bits i*TAG_W |
| in_data | input | C*DATA_W | Payloads, input i at bits i*DATA_W |
| out_valid | output | C | Per output: a copy is offered |
| out_ready | input | C | Per output: downstream takes the copy |
| out_tag | output | C*SUB_W | Narrowed tags, output j at bits j*SUB_W |
| out_data | output | C*DATA_W | Copy payloads, output j at bits j*DATA_W |

## Verification
The assertions assume that every offered input packet keeps valid, tag and payload steady until it is accepted. They also assume that reset is held for at least one edge before traffic starts. The stimulus changes an input only after a recorded handshake on that input or while its valid is low. It drives every input and ready from one process at the falling clock edge. Output ready is toggled at random and may stay low for long stretches, which the assertions allow. Tags mix random patterns, forced broadcast and all-zero values.

// File: rtl/msw_pkg.sv
package msw_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // Galois shift with a maximal-length tap set for 16 bits.
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction
endpackage

// File: rtl/msw_lfsr.sv
module msw_lfsr
  import msw_pkg::*;
#(
  parameter lfsr_t SEED = 16'hACE1
) (
  input  logic  clk,
  input  logic  rst,
  output lfsr_t state
);
  localparam lfsr_t START = (SEED == '0) ? lfsr_t'(1) : SEED;

  always_ff @(posedge clk) begin
    if (rst) state <= START;
    else     state <= lfsr_step(state);
  end
endmodule

// File: rtl/msw_pick.sv
module msw_pick
  import msw_pkg::*;
#(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  input  lfsr_t        rnd,
  output logic [N-1:0] gnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  int              base;
  int              pos;
  logic [IDX_W-1:0] idx;
  logic            found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    base  = int'(rnd % lfsr_t'(N));
    pos   = 0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      pos = (base + k) % N;
      idx = IDX_W'(pos);
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/msw_slot.sv
module msw_slot #(
  parameter int C      = 2,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic [C-1:0]      taken,
  output logic [C-1:0]      pend,
  output logic [TAG_W-1:0]  held_tag,
  output logic [DATA_W-1:0] held_data
);
  localparam int SUB_W = TAG_W / C;

  logic [C-1:0] want;
  logic         load;

  for (genvar j = 0; j < C; j++) begin : g_want
    assign want[j] = |in_tag[j*SUB_W +: SUB_W];
  end

  assign in_ready = ~|pend;
  assign load     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      held_tag  <= '0;
      held_data <= '0;
    end else if (load) begin
      pend      <= want;
      held_tag  <= in_tag;
      held_data <= in_data;
    end else begin
      pend      <= pend & ~taken;
    end
  end
endmodule

// File: rtl/msw_switch.sv
module msw_switch
  import msw_pkg::*;
#(
  parameter int    C         = 2,
  parameter int    TAG_W     = 8,
  parameter int    DATA_W    = 8,
  parameter lfsr_t LFSR_SEED = 16'hACE1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [C-1:0]            in_valid,
  output logic [C-1:0]            in_ready,
  input  logic [C*TAG_W-1:0]      in_tag,
  input  logic [C*DATA_W-1:0]     in_data,
  output logic [C-1:0]            out_valid,
  input  logic [C-1:0]            out_ready,
  output logic [C*(TAG_W/C)-1:0]  out_tag,
  output logic [C*DATA_W-1:0]     out_data
);
  localparam int SUB_W = TAG_W / C;

  logic [C*C-1:0]      pend_flat;   // input i, output j at i*C+j
  logic [C*C-1:0]      grant_flat;  // output j, input i at j*C+i
  logic [C*C-1:0]      taken_flat;  // input i, output j at i*C+j
  logic [C*TAG_W-1:0]  held_tag_all;
  logic [C*DATA_W-1:0] held_data_all;

  for (genvar i = 0; i < C; i++) begin : g_in
    for (genvar j = 0; j < C; j++) begin : g_tk
      assign taken_flat[i*C+j] = grant_flat[j*C+i] & out_ready[j];
    end
    msw_slot #(.C(C), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid[i]),
      .in_ready  (in_ready[i]),
      .in_tag    (in_tag[i*TAG_W +: TAG_W]),
      .in_data   (in_data[i*DATA_W +: DATA_W]),
      .taken     (taken_flat[i*C +: C]),
      .pend      (pend_flat[i*C +: C]),
      .held_tag  (held_tag_all[i*TAG_W +: TAG_W]),
      .held_data (held_data_all[i*DATA_W +: DATA_W])
    );
  end

  for (genvar j = 0; j < C; j++) begin : g_out
    localparam lfsr_t OSEED = LFSR_SEED ^ lfsr_t'((j + 1) * 16'h1357);

    logic [C-1:0]      req;
    logic [C-1:0]      pick;
    logic [C-1:0]      gnt;
    logic [C-1:0]      hold_q;
    logic              lock_q;
    lfsr_t             rnd;
    logic [SUB_W-1:0]  tag_mux;
    logic [DATA_W-1:0] data_mux;

    for (genvar i = 0; i < C; i++) begin : g_req
      assign req[i] = pend_flat[i*C+j];
    end

    msw_lfsr #(.SEED(OSEED)) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .state (rnd)
    );

    msw_pick #(.N(C)) u_pick (
      .req (req),
      .rnd (rnd),
      .gnt (pick)
    );

    // A stalled offer keeps its winner so the copy stays stable.
    assign gnt = lock_q ? hold_q : pick;
    assign grant_flat[j*C +: C] = gnt;
    assign out_valid[j] = |gnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_q <= 1'b0;
        hold_q <= '0;
      end else begin
        lock_q <= out_valid[j] & ~out_ready[j];
        hold_q <= gnt;
      end
    end

    always_comb begin
      tag_mux  = '0;
      data_mux = '0;
      for (int i = 0; i < C; i++) begin
        if (gnt[i]) begin
          tag_mux  = tag_mux  | held_tag_all[i*TAG_W + j*SUB_W +: SUB_W];
          data_mux = data_mux | held_data_all[i*DATA_W +: DATA_W];
        end
      end
    end

    assign out_tag[j*SUB_W +: SUB_W]    = tag_mux;
    assign out_data[j*DATA_W +: DATA_W] = data_mux;
  end
endmodule

// File: rtl/msw_checker.sv
module msw_checker #(
  parameter int C      = 2,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [C-1:0]           in_ready,
  input logic [C-1:0]           out_valid,
  input logic [C-1:0]           out_ready,
  input logic [C*(TAG_W/C)-1:0] out_tag,
  input logic [C*DATA_W-1:0]    out_data,
  input logic [C*C-1:0]         pend_flat,
  input logic [C*C-1:0]         grant_flat
);
  localparam int SUB_W = TAG_W / C;

  // R1: reset leaves every output quiet and every input open.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (out_valid == '0) && (in_ready == '1));

  for (genvar j = 0; j < C; j++) begin : g_o
    // R7: a stalled offer is repeated unchanged.
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid[j] && !out_ready[j] |=> out_valid[j]
        && $stable(out_tag[j*SUB_W +: SUB_W])
        && $stable(out_data[j*DATA_W +: DATA_W]));

    // R3: no copy leaves with an empty slice.
    assert_nonzero_tag_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid[j] |-> (out_tag[j*SUB_W +: SUB_W] != '0));

    // R6: at most one input is connected to an output.
    assert_one_winner_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_flat[j*C +: C]));
  end

  for (genvar i = 0; i < C; i++) begin : g_i
    for (genvar j = 0; j < C; j++) begin : g_ij
      // R6: a grant only goes to an input that still owes that copy.
      assert_grant_pending_R6: assert property (@(posedge clk) disable iff (rst)
        grant_flat[j*C+i] |-> pend_flat[i*C+j]);
    end
    // R5: while a packet is held, owed copies only ever drop away.
    assert_mask_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
      (|pend_flat[i*C +: C]) |=>
        ((pend_flat[i*C +: C] & ~$past(pend_flat[i*C +: C])) == '0));
    // R8: a busy slot refuses new packets.
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
      (|pend_flat[i*C +: C]) |-> !in_ready[i]);
  end
endmodule

bind msw_switch msw_checker #(.C(C), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_tag    (out_tag),
  .out_data   (out_data),
  .pend_flat  (pend_flat),
  .grant_flat (grant_flat)
);

// File: tb/tb_msw_switch.sv
module tb_msw_switch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  iv = '0;
  logic [15:0] itag = '0;
  logic [15:0] idat = '0;
  logic [1:0]  ordy = '0;
  logic [1:0]  in_ready;
  logic [1:0]  out_valid;
  logic [7:0]  out_tag;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [11:0] expm [0:1][0:1][0:255];
  int wp [0:1][0:1];
  int rp [0:1][0:1];
  logic [1:0]  prev_stall = '0;
  logic [11:0] prev_copy [0:1];
  logic [6:0]  cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msw_switch dut (
    .clk (clk), .rst (rst),
    .in_valid (iv), .in_ready (in_ready), .in_tag (itag), .in_data (idat),
    .out_valid (out_valid), .out_ready (ordy), .out_tag (out_tag), .out_data (out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Observe one cycle's handshakes, then advance to the next falling edge.
  task automatic tick();
    logic [1:0]  fired;
    logic [3:0]  sub;
    logic [11:0] got;
    int          src;
    int          k;
    #1;
    fired = iv & in_ready;
    for (int i = 0; i < 2; i++) begin
      if (fired[i]) begin
        for (int j = 0; j < 2; j++) begin
          sub = itag[i*8 + j*4 +: 4];
          if (sub != 4'h0) begin
            expm[j][i][wp[j][i] % 256] = {sub, idat[i*8 +: 8]};
            wp[j][i]++;
          end
        end
      end
    end
    for (int j = 0; j < 2; j++) begin
      got = {out_tag[j*4 +: 4], out_data[j*8 +: 8]};
      if (prev_stall[j])
        chk(out_valid[j] && got == prev_copy[j], "R7 held offer", {19'd0, out_valid[j], got}, {20'd1, prev_copy[j]});
      if (out_valid[j] && ordy[j]) begin
        src = int'(out_data[j*8 + 7]);
        if (rp[j][src] == wp[j][src]) begin
          chk(1'b0, "R3 unexpected copy", {20'd0, got}, 32'd0);
        end else begin
          k = rp[j][src] % 256;
          chk(got == expm[j][src][k], "R2 copy tag/payload", {20'd0, got}, {20'd0, expm[j][src][k]});
          rp[j][src]++;
        end
      end
      prev_stall[j] = out_valid[j] && !ordy[j];
      prev_copy[j]  = got;
    end
    @(negedge clk);
    for (int i = 0; i < 2; i++) if (fired[i]) iv[i] = 1'b0;
  endtask

  task automatic offer(input int i, input logic [7:0] t);
    iv[i] = 1'b1;
    cnt = cnt + 7'd1;
    itag[i*8 +: 8] = t;
    idat[i*8 +: 8] = {i[0], cnt};
  endtask

  task automatic drain(input int n);
    ordy = 2'b11;
    repeat (n) tick();
  endtask

  task automatic gen(input int mode, input int load, input int rdy);
    logic [7:0] t;
    for (int i = 0; i < 2; i++) begin
      if (!iv[i] && int'($urandom % 100) < load) begin
        case (mode)
          0: t = 8'($urandom);
          1: t = {4'($urandom % 15 + 1), 4'($urandom % 15 + 1)};
          default: begin
            if ($urandom % 3 == 0) t = 8'h00;
            else if ($urandom % 2 == 0) t = {4'h0, 4'($urandom)};
            else t = {4'($urandom), 4'h0};
          end
        endcase
        offer(i, t);
      end
    end
    for (int j = 0; j < 2; j++) ordy[j] = (int'($urandom % 100) < rdy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int wins [0:1];
    void'($urandom(32'd20240611));
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin wp[a][b] = 0; rp[a][b] = 0; end
    wins[0] = 0; wins[1] = 0;

    repeat (3) @(negedge clk);
    chk(out_valid == 2'b00 && in_ready == 2'b11, "R1 reset state", {28'd0, out_valid, in_ready}, 32'h3);
    rst = 1'b0;
    #1;
    chk(out_valid == 2'b00 && in_ready == 2'b11, "R1 after reset", {28'd0, out_valid, in_ready}, 32'h3);
    @(negedge clk);

    // R4: all-zero tag is absorbed.
    ordy = 2'b11;
    offer(0, 8'h00);
    tick();
    #1;
    chk(out_valid == 2'b00, "R4 no copy for zero tag", {30'd0, out_valid}, 32'd0);
    chk(in_ready[0] == 1'b1, "R4 input still ready", {31'd0, in_ready[0]}, 32'd1);
    drain(3);

    // R5/R8: copies leave independently under one-sided backpressure.
    offer(0, 8'h31);
    ordy = 2'b01;
    tick();
    #1;
    chk(out_valid == 2'b11, "R5 both copies offered", {30'd0, out_valid}, 32'h3);
    tick();
    #1;
    chk(out_valid == 2'b10, "R5 sibling gone, blocked copy waits", {30'd0, out_valid}, 32'h2);
    chk(in_ready[0] == 1'b0, "R8 busy while copy pending", {31'd0, in_ready[0]}, 32'd0);
    tick();
    tick();
    ordy = 2'b11;
    tick();
    #1;
    chk(in_ready[0] == 1'b1 && out_valid == 2'b00, "R8 free after last copy", {30'd0, in_ready[0], out_valid[1]}, 32'h2);
    tick();

    // R6: two inputs contend for output 0.
    offer(0, 8'h02);
    offer(1, 8'h02);
    tick();
    #1;
    chk(out_valid == 2'b01, "R6 one copy on contended output", {30'd0, out_valid}, 32'h1);
    tick();
    #1;
    chk(out_valid == 2'b01 && in_ready != 2'b11, "R6 loser served next", {28'd0, out_valid, in_ready}, 32'h5);
    tick();
    drain(2);

    // R9: repeated contention, count first winners.
    for (int n = 0; n < 60; n++) begin
      offer(0, 8'h04);
      offer(1, 8'h04);
      tick();
      #1;
      wins[int'(out_data[7])]++;
      tick();
      tick();
    end
    chk(wins[0] >= 8, "R9 input 0 wins share", wins[0], 32'd8);
    chk(wins[1] >= 8, "R9 input 1 wins share", wins[1], 32'd8);

    // Random traffic in three tag mixes and two backpressure levels.
    for (int c = 0; c < 3000; c++) begin
      gen(c / 1000, 70, (c % 400 < 200) ? 85 : 30);
      tick();
    end
    for (int c = 0; c < 60; c++) begin
      ordy = 2'b11;
      tick();
    end
    chk(iv == 2'b00 && in_ready == 2'b11 && out_valid == 2'b00, "R6 drained and idle", {28'd0, iv, out_valid}, 32'd0);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        chk(rp[a][b] == wp[a][b], "R3 every expected copy delivered", rp[a][b], wp[a][b]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule